// File: doc/BRIEF.md
# Programmable Serial Flash Command Shifter

This block sends one short command to a serial NOR flash and captures the reply. Software works through a small byte-wide register bus. It fills a bank of six transmit byte registers with the opcode and any argument bytes, writes a total bit count, and then writes a command code. The engine lowers chip select and clocks the bits out on MOSI, most significant bit first, in SPI mode 0. At the same time it samples MISO into a bank of ten receive byte registers.

Two shortcut commands need no buffer setup. The read-status shortcut inserts the status-read opcode itself and leaves the returned byte in a dedicated status register. The write-status shortcut inserts the status-write opcode and follows it with the top transmit byte. The command register shows the running code until the transfer ends, so software polls it for zero. Commands are refused until an enable value has been written to a guard register.

Top module: `spi_cmd_shifter`

## Requirements
- R1: Command writes are accepted only while the guard register (address 0x03) holds the enable value 0x30. Writing any other value there locks the engine again. The guard reads back 0x30 when enabled and 0x00 when locked, and its reset state is locked.
- R2: Writing code 0x04, 0x02 or 0x20 to the command register (address 0x00) starts an operation. The register reads back that code while the operation runs and 0x00 once it has ended. Any other code is ignored and leaves the register at 0x00.
- R3: The general command (0x04) shifts the number of bits held in the count register (address 0x01), limited to 56. A count of 0 ends the command without asserting chip select.
- R4: Transmit byte i sits at address 0x08+i, for i = 0..5. The general command sends byte 5 first, then bytes in descending index, and sends zero bytes after byte 0.
- R5: Sampled bits shift into the receive bank, which is read at address 0x10+j for j = 0..9. Each byte arrives MSB first. The last byte received is at j = 0, so for N bytes the first one is at j = N-1.
- R6: Read-status (0x02) sends opcode 0x05 and then clocks in one byte, 16 clocks in total. It stores the received byte in the status register (address 0x02).
- R7: Write-status (0x20) sends opcode 0x01 and then transmit byte 5, 16 clocks in total, whatever the count register holds.
- R8: SPI mode 0. SCK idles low and never pulses while chip select is high. MOSI changes only while SCK is low, and MISO is sampled on the rising edge. Chip select stays low over all bits of one command and rises once at its end.
- R9: A command written while an operation is running is ignored. It neither restarts nor alters the running transfer.
- R10: Register reads are registered: reg_rdata shows the register selected by reg_addr one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
General transfers run with random transmit bytes, random reply bytes and random lengths from one to seven bytes. This separates the descending transmit order and the placement of the last received byte at index 0 from a reversed or offset bank. Directed runs cover counts of zero and above the 56-bit limit, which tell clamping apart from wrap-around, and the two shortcuts, which show the inserted opcode and that the count register is not used. Commands written while locked, while busy, or with an unknown code expose any path that starts a transfer it should not.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // register addresses
  localparam int A_CMD     = 0;
  localparam int A_CNT     = 1;
  localparam int A_STAT    = 2;
  localparam int A_GUARD   = 3;
  localparam int A_TX_BASE = 8;
  localparam int A_RX_BASE = 16;

  // command codes and guard value
  localparam logic [7:0] CODE_GEN   = 8'h04;
  localparam logic [7:0] CODE_RDSR  = 8'h02;
  localparam logic [7:0] CODE_WRSR  = 8'h20;
  localparam logic [7:0] GUARD_OPEN = 8'h30;

  // flash opcodes inserted by the shortcuts
  localparam logic [7:0] FL_RDSR = 8'h05;
  localparam logic [7:0] FL_WRSR = 8'h01;

  typedef enum logic [1:0] {OP_GEN, OP_RDSR, OP_WRSR} op_kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_END} eng_state_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_TX = 6,
  parameter int NUM_RX = 10,
  localparam int TX_W = NUM_TX * 8,
  localparam int RX_W = NUM_RX * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              done,
  input  logic [RX_W-1:0]   rx_flat,
  input  logic [7:0]        status_byte,
  output logic              start,
  output op_kind_t          start_op,
  output logic [TX_W-1:0]   tx_flat,
  output logic [7:0]        bit_count,
  output logic              cmd_active
);
  logic [7:0] tx_q [NUM_TX];
  logic [7:0] cmd_q;
  logic       unlocked;
  logic       code_ok;
  logic [7:0] rd_mux;

  generate
    for (genvar i = 0; i < NUM_TX; i++) begin : g_txflat
      assign tx_flat[i*8 +: 8] = tx_q[i];
    end
  endgenerate

  always_comb begin
    code_ok  = 1'b1;
    start_op = OP_GEN;
    case (reg_wdata)
      CODE_GEN:  start_op = OP_GEN;
      CODE_RDSR: start_op = OP_RDSR;
      CODE_WRSR: start_op = OP_WRSR;
      default:   code_ok  = 1'b0;
    endcase
  end

  assign start = reg_we && (reg_addr == ADDR_W'(A_CMD)) && unlocked &&
                 (cmd_q == 8'h00) && code_ok;
  assign cmd_active = (cmd_q != 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= 8'h00;
      unlocked  <= 1'b0;
      bit_count <= 8'h00;
      for (int i = 0; i < NUM_TX; i++) tx_q[i] <= 8'h00;
    end else begin
      if (done) cmd_q <= 8'h00;
      else if (start) cmd_q <= reg_wdata;
      if (reg_we) begin
        if (reg_addr == ADDR_W'(A_CNT))   bit_count <= reg_wdata;
        if (reg_addr == ADDR_W'(A_GUARD)) unlocked  <= (reg_wdata == GUARD_OPEN);
        for (int i = 0; i < NUM_TX; i++)
          if (reg_addr == ADDR_W'(A_TX_BASE + i)) tx_q[i] <= reg_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (reg_addr == ADDR_W'(A_CMD))   rd_mux = cmd_q;
    if (reg_addr == ADDR_W'(A_CNT))   rd_mux = bit_count;
    if (reg_addr == ADDR_W'(A_STAT))  rd_mux = status_byte;
    if (reg_addr == ADDR_W'(A_GUARD)) rd_mux = unlocked ? GUARD_OPEN : 8'h00;
    for (int i = 0; i < NUM_TX; i++)
      if (reg_addr == ADDR_W'(A_TX_BASE + i)) rd_mux = tx_q[i];
    for (int j = 0; j < NUM_RX; j++)
      if (reg_addr == ADDR_W'(A_RX_BASE + j)) rd_mux = rx_flat[j*8 +: 8];
  end

  // R10 registered read path
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else     reg_rdata <= rd_mux;
  end

  // R1
  locked_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && cmd_q == 8'h00) |=> (cmd_q == 8'h00));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != 8'h00 && !done) |=> (cmd_q == $past(cmd_q)));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int NUM_TX    = 6,
  parameter int NUM_RX    = 10,
  parameter int MAX_BYTES = 7,
  parameter int SCK_HALF  = 2,
  localparam int TX_W     = NUM_TX * 8,
  localparam int RX_W     = NUM_RX * 8,
  localparam int MAX_BITS = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BITS + 1),
  localparam int TICK_W   = $clog2(SCK_HALF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  op_kind_t        start_op,
  input  logic [TX_W-1:0] tx_flat,
  input  logic [7:0]      bit_count,
  output logic            done,
  output logic [RX_W-1:0] rx_flat,
  output logic [7:0]      status_byte,
  output logic            spi_cs_n,
  output logic            spi_sck,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  eng_state_t          state;
  op_kind_t            op_q;
  logic [MAX_BITS-1:0] tx_sr;
  logic [MAX_BITS-1:0] load_val;
  logic [CNT_W-1:0]    bits_left;
  logic [CNT_W-1:0]    nbits;
  logic [TICK_W-1:0]   tick;
  logic                tick_done;

  assign tick_done = (tick == TICK_W'(SCK_HALF - 1));
  assign spi_mosi  = tx_sr[MAX_BITS-1];

  always_comb begin
    case (start_op)
      OP_RDSR: begin
        nbits    = CNT_W'(16);
        load_val = {FL_RDSR, {(MAX_BITS-8){1'b0}}};
      end
      OP_WRSR: begin
        nbits    = CNT_W'(16);
        load_val = {FL_WRSR, tx_flat[TX_W-1 -: 8], {(MAX_BITS-16){1'b0}}};
      end
      default: begin
        nbits    = (int'(bit_count) > MAX_BITS) ? CNT_W'(MAX_BITS) : CNT_W'(bit_count);
        load_val = {tx_flat, {(MAX_BITS-TX_W){1'b0}}};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_GEN;
      tx_sr       <= '0;
      rx_flat     <= '0;
      bits_left   <= '0;
      tick        <= '0;
      done        <= 1'b0;
      status_byte <= 8'h00;
      spi_cs_n    <= 1'b1;
      spi_sck     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          tick <= '0;
          op_q <= start_op;
          if (nbits == '0) begin
            done <= 1'b1;
          end else begin
            spi_cs_n  <= 1'b0;
            tx_sr     <= load_val;
            bits_left <= nbits;
            state     <= ST_LO;
          end
        end
        ST_LO: if (tick_done) begin
          tick    <= '0;
          spi_sck <= 1'b1;
          rx_flat <= {rx_flat[RX_W-2:0], spi_miso};
          state   <= ST_HI;
        end else tick <= tick + 1'b1;
        ST_HI: if (tick_done) begin
          tick      <= '0;
          spi_sck   <= 1'b0;
          tx_sr     <= {tx_sr[MAX_BITS-2:0], 1'b0};
          bits_left <= bits_left - 1'b1;
          state     <= (bits_left == CNT_W'(1)) ? ST_END : ST_LO;
        end else tick <= tick + 1'b1;
        default: if (tick_done) begin
          tick     <= '0;
          spi_cs_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
          if (op_q == OP_RDSR) status_byte <= rx_flat[7:0];
        end else tick <= tick + 1'b1;
      endcase
    end
  end

  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));
  // R3
  bit_limit_chk: assert property (@(posedge clk) disable iff (rst)
    bits_left <= CNT_W'(MAX_BITS));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int NUM_TX    = 6,
  parameter int NUM_RX    = 10,
  parameter int MAX_BYTES = 7,
  parameter int SCK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int TX_W = NUM_TX * 8;
  localparam int RX_W = NUM_RX * 8;

  logic            start, done, cmd_active;
  op_kind_t        start_op;
  logic [TX_W-1:0] tx_flat;
  logic [RX_W-1:0] rx_flat;
  logic [7:0]      bit_count, status_byte;

  spi_cmd_regs #(.ADDR_W(ADDR_W), .NUM_TX(NUM_TX), .NUM_RX(NUM_RX)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .rx_flat(rx_flat), .status_byte(status_byte), .start(start),
    .start_op(start_op), .tx_flat(tx_flat), .bit_count(bit_count),
    .cmd_active(cmd_active));

  spi_cmd_engine #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .MAX_BYTES(MAX_BYTES),
                   .SCK_HALF(SCK_HALF)) eng_i (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .tx_flat(tx_flat), .bit_count(bit_count), .done(done),
    .rx_flat(rx_flat), .status_byte(status_byte), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // R2 command code clears after chip select is released
  cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> ##1 !cmd_active);
endmodule

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int n_chk = 0, n_bad = 0;
  int bitpos = 0, ncap = 0, cs_rise = 0, bad_sck = 0;
  logic [63:0] cap = '0;
  logic [55:0] rep_vec = '0;
  logic [7:0]  txv [6];
  bit          finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_cmd_shifter dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // flash model: reply stream, MSB of byte 0 first, shifted on SCK fall
  assign spi_miso = (bitpos < 56) ? rep_vec[55 - bitpos] : 1'b0;

  initial forever begin
    @(posedge spi_sck);
    cap = {cap[62:0], spi_mosi};
    ncap++;
    if (spi_cs_n) bad_sck++;
  end
  initial forever begin @(negedge spi_sck); bitpos++; end
  initial forever begin @(posedge spi_cs_n); cs_rise++; end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // R10: data appears one clock after the address
  task automatic bus_rd(int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 5'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_mon();
    bitpos = 0; ncap = 0; cs_rise = 0; cap = '0;
  endtask

  task automatic wait_done(string req);
    logic [7:0] c;
    int n = 0;
    do begin bus_rd(0, c); n++; end while (c != 8'h00 && n < 2000);
    chk({req, " completion"}, 64'(c), 64'h0);
  endtask

  function automatic logic [7:0] cap_byte(int k);
    return cap[(ncap - 1 - 8*k) -: 8];
  endfunction

  function automatic logic [7:0] exp_tx(int k);
    return (k < 6) ? txv[5 - k] : 8'h00;
  endfunction

  task automatic load_tx();
    for (int i = 0; i < 6; i++) begin
      txv[i] = 8'($urandom);
      bus_wr(8 + i, txv[i]);
    end
  endtask

  task automatic run_general(int cnt, bit peek);
    int nb;
    logic [7:0] d;
    nb = ((cnt > 56) ? 56 : cnt) / 8;
    load_tx();
    bus_wr(1, 8'(cnt));
    rep_vec = {$urandom, $urandom};
    clear_mon();
    bus_wr(0, 8'h04);
    if (peek) begin
      bus_rd(0, d);
      chk("R2 busy readback", 64'(d), 64'h04);
    end
    wait_done("R2");
    chk("R3 bit count", 64'(ncap), 64'(nb*8));
    chk("R8 single cs release", 64'(cs_rise), 64'(nb > 0 ? 1 : 0));
    for (int k = 0; k < nb; k++)
      chk("R4 tx byte order", 64'(cap_byte(k)), 64'(exp_tx(k)));
    for (int j = 0; j < nb; j++) begin
      bus_rd(16 + j, d);
      chk("R5 rx placement", 64'(d), 64'(rep_vec[55 - 8*(nb-1-j) -: 8]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, st;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset cs_n", 64'(spi_cs_n), 64'h1);
    chk("R8 reset sck", 64'(spi_sck), 64'h0);
    bus_rd(0, d); chk("R2 reset cmd", 64'(d), 64'h0);
    bus_rd(3, d); chk("R1 reset guard", 64'(d), 64'h0);

    // R1 locked: command ignored
    bus_wr(1, 8'd16); clear_mon();
    bus_wr(0, 8'h04);
    bus_rd(0, d); chk("R1 locked cmd", 64'(d), 64'h0);
    repeat (40) @(negedge clk);
    chk("R1 locked no bits", 64'(ncap), 64'h0);

    bus_wr(3, 8'h30);
    bus_rd(3, d); chk("R1 guard open", 64'(d), 64'h30);

    // R6 read status
    rep_vec = {$urandom, $urandom}; clear_mon();
    bus_wr(0, 8'h02);
    wait_done("R6");
    chk("R6 clocks", 64'(ncap), 64'd16);
    chk("R6 opcode", 64'(cap_byte(0)), 64'h05);
    bus_rd(2, st); chk("R6 status byte", 64'(st), 64'(rep_vec[47:40]));

    // R7 write status, count register ignored
    load_tx(); bus_wr(1, 8'd40); clear_mon();
    bus_wr(0, 8'h20);
    wait_done("R7");
    chk("R7 clocks", 64'(ncap), 64'd16);
    chk("R7 opcode", 64'(cap_byte(0)), 64'h01);
    chk("R7 data", 64'(cap_byte(1)), 64'(txv[5]));

    // directed lengths
    run_general(8, 1);
    run_general(56, 0);
    run_general(200, 0);  // R3 clamp to 56
    // R3 zero count
    clear_mon(); bus_wr(1, 8'd0); bus_wr(0, 8'h04);
    wait_done("R3 zero");
    chk("R3 zero no bits", 64'(ncap), 64'h0);
    chk("R3 zero no cs", 64'(cs_rise), 64'h0);

    // random lengths
    for (int it = 0; it < 20; it++) run_general(8 * (1 + ($urandom % 7)), it[0]);

    // R9 command during busy is ignored
    load_tx(); bus_wr(1, 8'd24); rep_vec = {$urandom, $urandom}; clear_mon();
    bus_wr(0, 8'h04);
    bus_wr(0, 8'h02);
    bus_rd(0, d); chk("R9 code kept", 64'(d), 64'h04);
    wait_done("R9");
    chk("R9 bit count", 64'(ncap), 64'd24);
    bus_rd(2, d); chk("R9 status untouched", 64'(d), 64'(st));

    // R2 unknown code
    clear_mon(); bus_wr(0, 8'h07);
    bus_rd(0, d); chk("R2 unknown code", 64'(d), 64'h0);
    repeat (40) @(negedge clk);
    chk("R2 unknown no bits", 64'(ncap), 64'h0);

    // R1 relock
    bus_wr(3, 8'h55);
    bus_rd(3, d); chk("R1 relock", 64'(d), 64'h0);
    clear_mon(); bus_wr(0, 8'h02);
    repeat (40) @(negedge clk);
    chk("R1 relocked no bits", 64'(ncap), 64'h0);

    chk("R8 sck with cs high", 64'(bad_sck), 64'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule